// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block sits beside a processor core and watches two streams: the address of each instruction fetch and the data accesses made by instructions as they execute. It holds four breakpoint slots. Each slot has an address register and its own fields in a shared control word. When an armed slot sees a matching access, the block raises a one-cycle debug trap request and sets that slot's sticky bit in a status word. A trap flag from the core adds single-step traps. A resume flag lets the handler return to a faulting fetch without trapping again.

Software reaches the slots, the control word and the status word through a small register port. Only an access made at the most privileged level is honoured. Any other access is refused and recorded in the status word. Fetch hits trap before the instruction runs. Data hits and single-step wait until the instruction retires. Status bits are only ever set by hardware, and only a software write clears them.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset every address register and the control word read 0, status_o reads 32'hFFFF_0FF0, and trap_o is low.
- R2: A register access with `priv_i` low asserts `reg_err_o`, changes no register, reads 0 and sets status bit 13. With `priv_i` high, select 0–3 addresses slots 0–3, select 4 the control word and select 5 the status word. Selects 6–7 read 0 and ignore writes. The control word keeps only the bits in mask 32'hFFFF_00FF.
- R3: Control bits 2n and 2n+1 are two enables for slot n, and either one arms it. A slot with both enables clear never matches.
- R4: In the control word, bits 16+4n..17+4n hold slot n's access type and bits 18+4n..19+4n hold its length. A slot with type 00 and length 00 hits on a fetch whose address equals its address register exactly. That hit sets status bit n and raises trap_o for one cycle in the cycle after the fetch.
- R5: Type 01 matches data writes only. Type 11 matches data reads and writes. Neither type matches fetches, and type 00 ignores data accesses.
- R6: A data slot covers an aligned window: 1 byte for length 00, 2 bytes for 01 and 4 bytes for 11, with the address's low bits cleared. A data access covers `data_size_i`+1 bytes starting at `data_addr_i`. The slot hits when any accessed byte falls inside its window.
- R7: A slot with type 10 or length 10 never matches. A type-00 slot whose length is not 00 never matches.
- R8: A data hit is held until `retire_i`. It sets its status bit, and trap_o pulses, in the cycle after the retire, never earlier.
- R9: When an instruction retires and the trap flag was already set at the previous retire, status bit 14 is set and trap_o pulses in the next cycle. The instruction that first sets the flag does not trap.
- R10: While `rf_i` is high, fetch hits are suppressed.
- R11: Status bits 0–3, 13 and 14 are sticky. A privileged status write loads them from the written data, and a hardware set in the same cycle wins.
- R12: Status bits 4–11 and 16–31 always read 1, and bits 12 and 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Access is a write |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Write data |
| priv_i | input | 1 | Access is made at the most privileged level |
| reg_rdata_o | output | 32 | Read data (combinational) |
| reg_err_o | output | 1 | Access refused |
| fetch_valid_i | input | 1 | Instruction fetch this cycle |
| fetch_addr_i | input | ADDR_W | Fetch address |
| data_valid_i | input | 1 | Data access this cycle |
| data_addr_i | input | ADDR_W | Data address |
| data_size_i | input | 2 | Access size, bytes minus one |
| data_write_i | input | 1 | Data access is a write |
| retire_i | input | 1 | Current instruction retires |
| tf_i | input | 1 | Trap (single-step) flag |
| rf_i | input | 1 | Resume flag |
| trap_o | output | 1 | Debug trap request, one-cycle pulse |
| status_o | output | 32 | Status word |

## Verification
The slots are set up with fetch-exact, write-only, read-write and reserved codes. Accesses are then sent at addresses on, just off and straddling the window edges, with 1- to 4-byte sizes. This separates exact-fetch matching from window-overlap matching and read filtering from write filtering. Retire strobes are placed before, on and after data hits, which separates deferred reporting from immediate reporting. Toggling the trap flag shows the one-instruction delay before stepping starts. A random phase mixes all of these with resume-flag pulses, refused accesses and status clears. That phase checks every cycle's trap and status against a byte-by-byte bench model.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned SEL_W     = 3;

  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'hFFFF_00FF;
  localparam logic [DATA_W-1:0] STAT_ONES = 32'hFFFF_0FF0;
  localparam int unsigned       STAT_BD   = 13;
  localparam int unsigned       STAT_BS   = 14;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_RSVD  = 2'b10,
    ACC_RW    = 2'b11
  } acc_type_e;

  typedef enum logic [1:0] {
    LEN_1    = 2'b00,
    LEN_2    = 2'b01,
    LEN_RSVD = 2'b10,
    LEN_4    = 2'b11
  } len_e;

  typedef struct packed {
    logic      armed;
    acc_type_e acc;
    len_e      len;
  } slot_cfg_t;
endpackage

// File: rtl/dbg_bkpt_regs.sv
module dbg_bkpt_regs
  import dbg_bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               reg_en_i,
  input  logic                               reg_we_i,
  input  logic [SEL_W-1:0]                   reg_sel_i,
  input  logic [DATA_W-1:0]                  reg_wdata_i,
  input  logic                               priv_i,
  input  logic [NUM_SLOTS-1:0]               hw_b_i,
  input  logic                               hw_bs_i,
  output logic [DATA_W-1:0]                  reg_rdata_o,
  output logic                               reg_err_o,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]   bp_addr_o,
  output slot_cfg_t [NUM_SLOTS-1:0]          cfg_o,
  output logic [DATA_W-1:0]                  ctrl_o,
  output logic [DATA_W-1:0]                  status_o
);
  logic                 acc_ok, refused, wr_ctrl, wr_stat;
  logic [DATA_W-1:0]    ctrl_q;
  logic [NUM_SLOTS-1:0] b_q, b_d;
  logic                 bd_q, bd_d, bs_q, bs_d;

  assign acc_ok  = reg_en_i & priv_i;
  assign refused = reg_en_i & ~priv_i;
  assign wr_ctrl = acc_ok & reg_we_i & (reg_sel_i == SEL_CTRL);
  assign wr_stat = acc_ok & reg_we_i & (reg_sel_i == SEL_STAT);

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_addr
    logic [ADDR_W-1:0] addr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) addr_q <= '0;
      else if (acc_ok && reg_we_i && reg_sel_i == SEL_W'(n))
        addr_q <= reg_wdata_i[ADDR_W-1:0];
    end
    assign bp_addr_o[n]   = addr_q;
    assign cfg_o[n].armed = ctrl_q[2*n] | ctrl_q[2*n+1];
    assign cfg_o[n].acc   = acc_type_e'(ctrl_q[16+4*n +: 2]);
    assign cfg_o[n].len   = len_e'(ctrl_q[18+4*n +: 2]);
  end

  always_comb begin
    b_d  = (wr_stat ? reg_wdata_i[NUM_SLOTS-1:0] : b_q) | hw_b_i;
    bd_d = (wr_stat ? reg_wdata_i[STAT_BD] : bd_q) | refused;
    bs_d = (wr_stat ? reg_wdata_i[STAT_BS] : bs_q) | hw_bs_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      b_q    <= '0;
      bd_q   <= 1'b0;
      bs_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i & CTRL_MASK;
      b_q  <= b_d;
      bd_q <= bd_d;
      bs_q <= bs_d;
    end
  end

  always_comb begin
    status_o                  = STAT_ONES;
    status_o[NUM_SLOTS-1:0]   = b_q;
    status_o[STAT_BD]         = bd_q;
    status_o[STAT_BS]         = bs_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (acc_ok) begin
      if (reg_sel_i < SEL_W'(NUM_SLOTS))
        reg_rdata_o = DATA_W'(bp_addr_o[reg_sel_i[1:0]]);
      else if (reg_sel_i == SEL_CTRL)
        reg_rdata_o = ctrl_q;
      else if (reg_sel_i == SEL_STAT)
        reg_rdata_o = status_o;
    end
  end

  assign reg_err_o = refused;
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/dbg_bkpt_slot.sv
module dbg_bkpt_slot
  import dbg_bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  slot_cfg_t         cfg_i,
  input  logic [ADDR_W-1:0] bp_addr_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              rf_i,
  input  logic              data_valid_i,
  input  logic [ADDR_W-1:0] data_addr_i,
  input  logic [1:0]        data_size_i,
  input  logic              data_write_i,
  output logic              fetch_hit_o,
  output logic              data_hit_o
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic             cfg_ok, type_ok, overlap;
  logic [EXT_W-1:0] w_lo, w_hi, a_lo, a_hi;

  assign cfg_ok = cfg_i.armed && cfg_i.acc != ACC_RSVD && cfg_i.len != LEN_RSVD;

  assign fetch_hit_o = cfg_ok && cfg_i.acc == ACC_FETCH && cfg_i.len == LEN_1 &&
                       fetch_valid_i && !rf_i && fetch_addr_i == bp_addr_i;

  // length code doubles as the window's low-bit mask (00->0, 01->1, 11->3)
  always_comb begin
    w_lo = {1'b0, bp_addr_i & ~ADDR_W'(cfg_i.len)};
    w_hi = w_lo + EXT_W'(cfg_i.len);
    a_lo = {1'b0, data_addr_i};
    a_hi = a_lo + EXT_W'(data_size_i);
  end

  assign overlap = (a_lo <= w_hi) && (w_lo <= a_hi);
  assign type_ok = (cfg_i.acc == ACC_RW) || (cfg_i.acc == ACC_WRITE && data_write_i);
  assign data_hit_o = cfg_ok && data_valid_i && type_ok && overlap;
endmodule

// File: rtl/dbg_bkpt_step.sv
module dbg_bkpt_step (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic retire_i,
  input  logic tf_i,
  output logic step_o
);
  logic arm_q;

  // flag sampled at each retire; a step trap needs it set before the instruction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       arm_q <= 1'b0;
    else if (retire_i) arm_q <= tf_i;
  end

  assign step_o = retire_i & arm_q;
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
  import dbg_bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              priv_i,
  output logic [31:0]       reg_rdata_o,
  output logic              reg_err_o,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              data_valid_i,
  input  logic [ADDR_W-1:0] data_addr_i,
  input  logic [1:0]        data_size_i,
  input  logic              data_write_i,
  input  logic              retire_i,
  input  logic              tf_i,
  input  logic              rf_i,
  output logic              trap_o,
  output logic [31:0]       status_o
);
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] bp_addr;
  slot_cfg_t [NUM_SLOTS-1:0]        cfg;
  logic [DATA_W-1:0]                ctrl_w;
  logic [NUM_SLOTS-1:0]             fetch_hit, data_hit, pend_q, flush, hw_b;
  logic                             step, trap_q;

  dbg_bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .reg_en_i, .reg_we_i, .reg_sel_i, .reg_wdata_i, .priv_i,
    .hw_b_i(hw_b), .hw_bs_i(step), .reg_rdata_o, .reg_err_o,
    .bp_addr_o(bp_addr), .cfg_o(cfg), .ctrl_o(ctrl_w), .status_o
  );

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    dbg_bkpt_slot #(.ADDR_W(ADDR_W)) u_slot (
      .cfg_i(cfg[n]), .bp_addr_i(bp_addr[n]),
      .fetch_valid_i, .fetch_addr_i, .rf_i,
      .data_valid_i, .data_addr_i, .data_size_i, .data_write_i,
      .fetch_hit_o(fetch_hit[n]), .data_hit_o(data_hit[n])
    );
  end

  dbg_bkpt_step u_step (.clk_i, .rst_ni, .retire_i, .tf_i, .step_o(step));

  assign flush = retire_i ? (pend_q | data_hit) : '0;
  assign hw_b  = fetch_hit | flush;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      trap_q <= 1'b0;
    end else begin
      pend_q <= retire_i ? '0 : (pend_q | data_hit);
      trap_q <= (|fetch_hit) | (|flush) | step;
    end
  end

  assign trap_o = trap_q;
endmodule

// File: rtl/dbg_bkpt_chk.sv
module dbg_bkpt_chk
  import dbg_bkpt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_en_i,
  input logic              reg_we_i,
  input logic [2:0]        reg_sel_i,
  input logic              priv_i,
  input logic              fetch_valid_i,
  input logic              retire_i,
  input logic              rf_i,
  input logic              trap_o,
  input logic [31:0]       status_o,
  input logic [DATA_W-1:0] ctrl_w
);
  AST_STATUS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[31:16] == 16'hFFFF && status_o[11:4] == 8'hFF && !status_o[12] && !status_o[15]); // R12

  AST_STICKY_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_en_i && priv_i && reg_we_i && reg_sel_i == SEL_STAT)
    |=> ((status_o & $past(status_o)) == $past(status_o))); // R11

  AST_REFUSED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_en_i && !priv_i |=> ctrl_w == $past(ctrl_w)); // R2

  AST_REFUSED_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_en_i && !priv_i |=> status_o[STAT_BD]); // R2

  AST_RESUME_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_i && !retire_i |=> !trap_o); // R10

  AST_TRAP_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i && !retire_i |=> !trap_o); // R8
endmodule

bind dbg_bkpt_unit dbg_bkpt_chk u_chk (.*);

// File: tb/dbg_bkpt_unit_tb_top.sv
module dbg_bkpt_unit_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en = 0, we = 0, pv = 0, fv = 0, dv = 0, dw = 0, rt = 0, tf = 0, rf = 0;
  logic [2:0]  sel = '0;
  logic [1:0]  ds = '0;
  logic [31:0] wd = '0, fa = '0, da = '0;
  logic [31:0] rdata, status;
  logic        err, trap;

  int n_chk = 0, n_fail = 0;

  logic [31:0] m_bp [4];
  logic [31:0] m_ctrl;
  logic [3:0]  m_b, m_pend;
  logic        m_bd, m_bs, m_arm;

  always #4 clk_i = ~clk_i;

  dbg_bkpt_unit dut_i (
    .clk_i, .rst_ni, .reg_en_i(en), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wd),
    .priv_i(pv), .reg_rdata_o(rdata), .reg_err_o(err), .fetch_valid_i(fv),
    .fetch_addr_i(fa), .data_valid_i(dv), .data_addr_i(da), .data_size_i(ds),
    .data_write_i(dw), .retire_i(rt), .tf_i(tf), .rf_i(rf), .trap_o(trap), .status_o(status)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_status();
    logic [31:0] s = 32'hFFFF_0FF0;
    s[3:0] = m_b; s[13] = m_bd; s[14] = m_bs;
    return s;
  endfunction

  function automatic bit slot_ok(int n);
    logic [1:0] ty = m_ctrl[16+4*n +: 2];
    logic [1:0] ln = m_ctrl[18+4*n +: 2];
    return (m_ctrl[2*n] | m_ctrl[2*n+1]) && ty != 2'b10 && ln != 2'b10;
  endfunction

  function automatic bit f_hit(int n);
    return slot_ok(n) && m_ctrl[16+4*n +: 4] == 4'b0000 && fv && !rf && fa == m_bp[n];
  endfunction

  function automatic bit d_hit(int n);
    logic [1:0] ty = m_ctrl[16+4*n +: 2];
    logic [1:0] ln = m_ctrl[18+4*n +: 2];
    longint unsigned sz, lo, hi, b;
    bit hit = 0;
    if (!slot_ok(n) || !dv) return 0;
    if (!(ty == 2'b11 || (ty == 2'b01 && dw))) return 0;
    sz = (ln == 2'b00) ? 1 : (ln == 2'b01) ? 2 : 4;
    lo = longint'(m_bp[n]) - (longint'(m_bp[n]) % sz);
    hi = lo + sz - 1;
    for (int k = 0; k <= int'(ds); k++) begin
      b = longint'(da) + k;
      if (b >= lo && b <= hi) hit = 1;
    end
    return hit;
  endfunction

  task automatic cyc(string tag);
    logic [3:0] fh, dh, fl;
    bit acc, etrap, wst;
    for (int n = 0; n < 4; n++) begin fh[n] = f_hit(n); dh[n] = d_hit(n); end
    acc   = en && pv;
    fl    = rt ? (m_pend | dh) : 4'b0;
    etrap = (|fh) || (|fl) || (rt && m_arm);
    wst   = acc && we && sel == 3'd5;
    @(posedge clk_i); #2;
    m_b  = (wst ? wd[3:0] : m_b) | fh | fl;
    m_bd = (wst ? wd[13] : m_bd) | (en && !pv);
    m_bs = (wst ? wd[14] : m_bs) | (rt && m_arm);
    if (acc && we && sel < 3'd4) m_bp[sel[1:0]] = wd;
    if (acc && we && sel == 3'd4) m_ctrl = wd & 32'hFFFF_00FF;
    m_pend = rt ? 4'b0 : (m_pend | dh);
    if (rt) m_arm = tf;
    chk(trap === etrap, {tag, " trap"}, 32'(trap), 32'(etrap));
    chk(status === m_status(), {tag, " status"}, status, m_status());
  endtask

  task automatic idle();
    en = 0; we = 0; fv = 0; dv = 0; dw = 0; rt = 0;
  endtask

  task automatic reg_wr(logic [2:0] s, logic [31:0] v, bit p, string tag);
    idle(); en = 1; we = 1; sel = s; wd = v; pv = p;
    #1 chk(err === !p, {tag, " err"}, 32'(err), 32'(!p));
    cyc(tag); idle();
  endtask

  task automatic reg_rd(logic [2:0] s, logic [31:0] exp, bit p, string tag);
    idle(); en = 1; sel = s; pv = p;
    #1 chk(rdata === exp, {tag, " rdata"}, rdata, exp);
    cyc(tag); idle();
  endtask

  task automatic fetch(logic [31:0] a, string tag);
    idle(); fv = 1; fa = a; cyc(tag); idle();
  endtask

  task automatic data(logic [31:0] a, logic [1:0] s, bit w, bit r, string tag);
    idle(); dv = 1; da = a; ds = s; dw = w; rt = r; cyc(tag); idle();
  endtask

  task automatic retire(string tag);
    idle(); rt = 1; cyc(tag); idle();
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    for (int n = 0; n < 4; n++) m_bp[n] = '0;
    m_ctrl = '0; m_b = '0; m_pend = '0; m_bd = 0; m_bs = 0; m_arm = 0;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    #1;
    chk(status === 32'hFFFF_0FF0, "R1 R12 reset status", status, 32'hFFFF_0FF0);
    chk(trap === 1'b0, "R1 reset trap", 32'(trap), 0);
    reg_rd(3'd4, 32'h0, 1, "R1 ctrl reset");
    reg_rd(3'd2, 32'h0, 1, "R1 addr reset");

    // slot 0: local enable, fetch, 1 byte
    reg_wr(3'd0, 32'h0000_1000, 1, "R2 wr bp0");
    reg_wr(3'd4, 32'h0000_FF01, 1, "R2 wr ctrl");
    reg_rd(3'd4, 32'h0000_0001, 1, "R2 ctrl mask");
    reg_rd(3'd0, 32'h0000_1000, 1, "R2 rd bp0");
    reg_rd(3'd7, 32'h0, 1, "R2 sel7");
    fetch(32'h1000, "R4 fetch hit");
    chk(trap === 1 && status[0] === 1, "R4 hit seen", status, 32'hFFFF_0FF1);
    fetch(32'h1001, "R4 fetch miss");
    chk(trap === 0, "R4 miss", 32'(trap), 0);
    rf = 1; fetch(32'h1000, "R10 resume"); rf = 0;
    chk(trap === 0, "R10 suppressed", 32'(trap), 0);

    reg_wr(3'd4, 32'h0, 0, "R2 refused");
    chk(status[13] === 1, "R2 BD set", status, m_status());
    reg_rd(3'd4, 32'h0, 0, "R2 refused read");
    reg_rd(3'd4, 32'h1, 1, "R2 ctrl kept");

    reg_wr(3'd5, 32'h0, 1, "R11 clear");
    chk(status === 32'hFFFF_0FF0, "R11 cleared", status, 32'hFFFF_0FF0);
    fetch(32'h1000, "R11 reset by hit");
    fetch(32'h2000, "R11 sticky");
    chk(status[0] === 1, "R11 sticky B0", status, m_status());

    // slot 1: global enable, write-only, 4 bytes at 0x2000..0x2003
    reg_wr(3'd1, 32'h0000_2002, 1, "R6 wr bp1");
    reg_wr(3'd4, 32'h00D0_0009, 1, "R5 wr ctrl");
    data(32'h2000, 2'd0, 0, 1, "R5 read ignored");
    chk(trap === 0, "R5 no read hit", 32'(trap), 0);
    fetch(32'h2002, "R5 fetch ignored");
    data(32'h2003, 2'd0, 1, 0, "R8 held");
    chk(trap === 0, "R8 not before retire", 32'(trap), 0);
    retire("R8 flush");
    chk(trap === 1 && status[1] === 1, "R8 after retire", status, m_status());
    data(32'h1FFF, 2'd1, 1, 1, "R6 straddle");
    chk(trap === 1, "R6 straddle hit", 32'(trap), 1);
    data(32'h2004, 2'd3, 1, 1, "R6 past window");
    chk(trap === 0, "R6 miss", 32'(trap), 0);
    data(32'h1FFC, 2'd3, 1, 1, "R6 below window");
    chk(trap === 0, "R6 below miss", 32'(trap), 0);

    // slot 2 with reserved length, slot 0 fetch with length 01
    reg_wr(3'd2, 32'h0000_3000, 1, "R7 wr bp2");
    reg_wr(3'd4, 32'h0B04_0011, 1, "R7 wr ctrl");
    data(32'h3000, 2'd0, 1, 1, "R7 rsvd len");
    fetch(32'h1000, "R7 fetch len01");
    chk(trap === 0, "R7 never", 32'(trap), 0);
    reg_wr(3'd4, 32'h0000_0000, 1, "R3 disable");
    fetch(32'h1000, "R3 disabled");
    chk(trap === 0, "R3 no arm", 32'(trap), 0);
    reg_wr(3'd4, 32'h0000_0002, 1, "R3 global");
    fetch(32'h1000, "R3 global arms");
    chk(trap === 1, "R3 global hit", 32'(trap), 1);

    // single step
    reg_wr(3'd5, 32'h0, 1, "R9 clear");
    tf = 1; retire("R9 setter");
    chk(trap === 0, "R9 delayed", 32'(trap), 0);
    retire("R9 step");
    chk(trap === 1 && status[14] === 1, "R9 trapped", status, m_status());
    tf = 0; retire("R9 last"); retire("R9 off");
    chk(trap === 0, "R9 stopped", 32'(trap), 0);

    // random phase
    for (int n = 0; n < 4; n++)
      reg_wr(3'(n), 32'h1000 + 32'(n * 8) + $urandom_range(0, 3), 1, "R6 rnd bp");
    for (int i = 0; i < 1500; i++) begin
      idle();
      if ($urandom_range(0, 29) == 0) begin
        en = 1; we = 1; pv = ($urandom_range(0, 3) != 0);
        sel = ($urandom_range(0, 1) != 0) ? 3'd4 : 3'd5;
        wd = (sel == 3'd4) ? $urandom() : 32'h0;
      end
      fv = $urandom_range(0, 1); fa = 32'h1000 + $urandom_range(0, 31);
      dv = $urandom_range(0, 1); da = 32'h1000 + $urandom_range(0, 34);
      ds = 2'($urandom_range(0, 3)); dw = $urandom_range(0, 1);
      rt = ($urandom_range(0, 2) == 0);
      tf = ($urandom_range(0, 5) == 0); rf = ($urandom_range(0, 4) == 0);
      cyc("R4 R5 R6 R7 R8 R9 R10 rnd");
    end
    idle(); tf = 0; rf = 0;

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule